// File: doc/BRIEF.md
# Frame-Synchronized Transport Packet Descrambler

This block removes the energy-dispersal randomization from a stream of 188-byte transport packets. Parity bytes have already been removed upstream, and a Reed-Solomon stage reports with each packet whether it could correct it. Each input byte comes with a strobe. A begin flag marks the sync byte of a packet. An uncorrectable flag is sampled with that sync byte and covers the whole packet.

A free-running block-of-frame counter tracks which of the eight packets of a frame is arriving. The counter is forced back to frame position 0 whenever a packet that is correct or corrected starts with the inverted sync value B8h. The first such event also sets a lock flag. A 15-stage pseudo-random generator with feedback polynomial 1 + x^14 + x^15 is loaded with a fixed seed on the sync byte of each frame's first packet. Its output bits are XORed, most significant bit first, onto every payload byte. The generator also steps through the sync byte of every other packet, but leaves that byte untouched, so its phase runs on without a break across the frame.

When the error-flag enable is set, the first bit after the sync byte is forced to 1 in every uncorrectable packet. That bit is the transport error indicator, bit 7 of payload byte 1. An output error flag is set for the whole of any packet that is uncorrectable or arrives before lock.

A small control machine tracks the position inside a packet and has three states. ST_IDLE is held from reset until the first sync byte. ST_TEI means the next byte is payload byte 1. ST_BODY covers the rest of the payload. Three transitions exist. T_SYNC goes from any state to ST_TEI on a strobed byte with begin set. T_FIRST goes from ST_TEI to ST_BODY on a strobed byte without begin. T_HOLD keeps ST_IDLE and ST_BODY as they are otherwise.

Top module: `ts_descrambler`

## Requirements
- R1: While reset is low and in the first cycle after it, out_stb and out_begin are 0, out_byte is 00h and out_err is 1.
- R2: Each cycle with in_stb high yields out_stb high in the next cycle, with out_begin equal to that input's in_begin. A cycle with in_stb low yields out_stb and out_begin low in the next cycle, whatever the other inputs carry.
- R3: Every sync byte (strobed with in_begin high) appears unchanged on out_byte.
- R4: A sync byte equal to B8h with in_uncorr low sets the frame position to 0 at any point in the frame and sets lock. A B8h sync byte with in_uncorr high does not resynchronize, and the counter simply advances.
- R5: On a sync byte whose new frame position is 0, the generator is loaded with seed 100101010000000 (stage 1 first). Each payload byte is XORed with the next 8 generator outputs, where output = stage14 XOR stage15 is fed back into stage 1 and the first output lands on bit 7.
- R6: A sync byte whose new frame position is not 0 steps the generator 8 times, and no output is applied to that byte.
- R7: The frame position starts at 0 after reset. Without a qualifying B8h it counts 1, 2, ... 7, 0 on successive sync bytes, and wrapping to 0 reloads the seed whatever the sync value.
- R8: With erf_en high, bit 7 of payload byte 1 of an uncorrectable packet is forced to 1 after descrambling. With erf_en low, that byte is only descrambled.
- R9: out_err is updated only in the cycle out_begin is high: to 1 if the packet is uncorrectable or lock is not yet set, else to 0. It stays constant until the next such cycle.
- R10: Bytes strobed before the first sync byte after reset pass unchanged, do not step the generator, and carry out_err high.
- R11: Cycles with in_stb low advance neither the packet position, the frame position nor the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erf_en | input | 1 | Enables forcing of the transport error bit in uncorrectable packets |
| in_byte | input | 8 | Input byte |
| in_stb | input | 1 | Input byte valid |
| in_begin | input | 1 | Input byte is the sync byte of a packet |
| in_uncorr | input | 1 | Packet is uncorrectable; sampled with the sync byte |
| out_byte | output | 8 | Descrambled byte |
| out_stb | output | 1 | Output byte valid |
| out_begin | output | 1 | Output byte is a sync byte |
| out_err | output | 1 | Packet is uncorrectable or frame lock not reached |

## Verification
Every result is due in the cycle right after the clock edge that takes the strobed byte in: out_byte, out_stb, out_begin and (for sync bytes) out_err all come from one register stage. The bench drives each byte on a falling edge and compares all outputs on the next falling edge, before it drives the following input. Gap cycles are compared in the same slot, so the output strobe must be low there, and the data that follows a gap must show that nothing moved. The err flag is compared on every byte, which checks both its update on the sync byte and that it does not change inside the packet.

// File: rtl/ts_descr_pkg.sv
package ts_descr_pkg;

    // Position of the control machine inside a packet
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no sync byte seen since reset
        ST_TEI  = 2'd1,   // next byte carries the transport error bit
        ST_BODY = 2'd2    // remaining payload bytes
    } pkt_state_t;

endpackage

// File: rtl/ts_frame_track.sv
module ts_frame_track #(
    parameter int          BYTE_W       = 8,
    parameter int          FRAME_BLOCKS = 8,
    parameter logic [7:0]  SYNC_FRAME   = 8'hB8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [BYTE_W-1:0] sync_byte,
    input  logic              bad,
    output logic              frame_start,
    output logic              lock_now
);

    localparam int PW = (FRAME_BLOCKS > 1) ? $clog2(FRAME_BLOCKS) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BLOCKS - 1);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos_d;
    logic          lock_q;
    logic          resync;

    assign resync = hit && (sync_byte == BYTE_W'(SYNC_FRAME)) && !bad;

    always_comb begin
        if (resync)
            pos_d = '0;
        else if (pos_q == LAST_POS)
            pos_d = '0;
        else
            pos_d = pos_q + PW'(1);
    end

    assign frame_start = hit && (pos_d == '0);
    assign lock_now    = lock_q || resync;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            lock_q <= 1'b0;
        end else if (hit) begin
            pos_q  <= pos_d;
            lock_q <= lock_now;
        end
    end

endmodule

// File: rtl/ts_prbs_gen.sv
module ts_prbs_gen #(
    parameter int                PRBS_W = 15,
    parameter int                TAP_A  = 14,
    parameter int                TAP_B  = 15,
    parameter logic [PRBS_W-1:0] SEED   = 15'h00A9,
    parameter int                BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    output logic [BYTE_W-1:0] mask
);

    // bit 0 holds stage 1, bit PRBS_W-1 holds the last stage
    logic [PRBS_W-1:0] st_q;
    logic [PRBS_W-1:0] st_adv;

    always_comb begin
        logic [PRBS_W-1:0] s;
        logic              fb;
        s    = st_q;
        mask = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            fb                 = s[TAP_A-1] ^ s[TAP_B-1];
            mask[BYTE_W-1-i]   = fb;
            s                  = {s[PRBS_W-2:0], fb};
        end
        st_adv = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= SEED;
        else if (load)
            st_q <= SEED;
        else if (adv)
            st_q <= st_adv;
    end

endmodule

// File: rtl/ts_pkt_fsm.sv
module ts_pkt_fsm
    import ts_descr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic begin_in,
    input  logic bad_in,
    output logic in_idle,
    output logic at_tei,
    output logic pkt_bad
);

    pkt_state_t state_q;
    pkt_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pkt_bad <= 1'b0;
        end else begin
            state_q <= state_d;
            if (stb && begin_in)
                pkt_bad <= bad_in;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (stb && begin_in) begin
            state_d = ST_TEI;                    // T_SYNC
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;      // T_HOLD
                ST_TEI:  if (stb) state_d = ST_BODY; // T_FIRST
                ST_BODY: state_d = ST_BODY;      // T_HOLD
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_idle = (state_q == ST_IDLE);
        at_tei  = (state_q == ST_TEI);
    end

endmodule

// File: rtl/ts_descrambler.sv
module ts_descrambler #(
    parameter int          BYTE_W       = 8,
    parameter int          FRAME_BLOCKS = 8,
    parameter logic [7:0]  SYNC_FRAME   = 8'hB8,
    parameter int          PRBS_W       = 15,
    parameter logic [14:0] PRBS_SEED    = 15'h00A9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erf_en,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_stb,
    input  logic              in_begin,
    input  logic              in_uncorr,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_stb,
    output logic              out_begin,
    output logic              out_err
);

    localparam logic [BYTE_W-1:0] TEI_MASK = BYTE_W'(1) << (BYTE_W - 1);

    logic              hit;
    logic              frame_start;
    logic              lock_now;
    logic              in_idle;
    logic              at_tei;
    logic              pkt_bad;
    logic              gen_load;
    logic              gen_adv;
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] payload_d;

    assign hit = in_stb && in_begin;

    ts_frame_track #(
        .BYTE_W      (BYTE_W),
        .FRAME_BLOCKS(FRAME_BLOCKS),
        .SYNC_FRAME  (SYNC_FRAME)
    ) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .sync_byte  (in_byte),
        .bad        (in_uncorr),
        .frame_start(frame_start),
        .lock_now   (lock_now)
    );

    ts_pkt_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (in_stb),
        .begin_in(in_begin),
        .bad_in  (in_uncorr),
        .in_idle (in_idle),
        .at_tei  (at_tei),
        .pkt_bad (pkt_bad)
    );

    assign gen_load = hit && frame_start;
    assign gen_adv  = in_stb && ((in_begin && !frame_start) || (!in_begin && !in_idle));

    ts_prbs_gen #(
        .PRBS_W(PRBS_W),
        .TAP_A (14),
        .TAP_B (15),
        .SEED  (PRBS_W'(PRBS_SEED)),
        .BYTE_W(BYTE_W)
    ) gen_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (gen_load),
        .adv  (gen_adv),
        .mask (mask)
    );

    always_comb begin
        payload_d = in_byte ^ mask;
        if (at_tei && erf_en && pkt_bad)
            payload_d = payload_d | TEI_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte  <= '0;
            out_stb   <= 1'b0;
            out_begin <= 1'b0;
            out_err   <= 1'b1;
        end else begin
            out_stb   <= in_stb;
            out_begin <= hit;
            if (in_stb)
                out_byte <= (in_begin || in_idle) ? in_byte : payload_d;
            if (hit)
                out_err <= in_uncorr || !lock_now;
        end
    end

endmodule

// File: rtl/ts_descrambler_chk.sv
module ts_descrambler_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] in_byte,
    input logic              in_stb,
    input logic              in_begin,
    input logic              in_uncorr,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_stb,
    input logic              out_begin,
    input logic              out_err
);

    // R2
    stb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_stb |=> out_stb);

    // R2
    stb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> (!out_stb && !out_begin));

    // R2
    begin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && in_begin) |=> out_begin);

    // R3
    sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && in_begin) |=> (out_byte == $past(in_byte)));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_begin |-> $stable(out_err));

    // R9
    err_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && in_begin && in_uncorr) |=> out_err);

endmodule

bind ts_descrambler ts_descrambler_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_byte  (in_byte),
    .in_stb   (in_stb),
    .in_begin (in_begin),
    .in_uncorr(in_uncorr),
    .out_byte (out_byte),
    .out_stb  (out_stb),
    .out_begin(out_begin),
    .out_err  (out_err)
);

// File: tb/ts_descrambler_tb_top.sv
module ts_descrambler_tb_top;

    localparam int PKT_LEN = 188;
    localparam logic [14:0] SEED = 15'b000000010101001; // stage1..15 = 100101010000000

    logic       clk = 1'b0;
    logic       rst_n;
    logic       erf_en;
    logic [7:0] in_byte;
    logic       in_stb;
    logic       in_begin;
    logic       in_uncorr;
    logic [7:0] out_byte;
    logic       out_stb;
    logic       out_begin;
    logic       out_err;

    always #4 clk = ~clk;

    ts_descrambler dut_i (
        .clk(clk), .rst_n(rst_n), .erf_en(erf_en),
        .in_byte(in_byte), .in_stb(in_stb), .in_begin(in_begin), .in_uncorr(in_uncorr),
        .out_byte(out_byte), .out_stb(out_stb), .out_begin(out_begin), .out_err(out_err)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // reference model state
    logic [14:0] m_st;
    int          m_pos;
    bit          m_lock;
    int          m_state;   // 0 idle, 1 tei next, 2 body
    bit          m_bad;
    bit          m_err;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] gen8(inout logic [14:0] st);
        logic [7:0] m;
        logic fb;
        m = 8'h00;
        for (int k = 0; k < 8; k++) begin
            fb = st[13] ^ st[14];
            m  = {m[6:0], fb};
            st = {st[13:0], fb};
        end
        return m;
    endfunction

    task automatic send(input logic [7:0] b, input bit bg, input bit uc, input string tag);
        logic [7:0] exp;
        logic [7:0] msk;
        string      dtag;
        dtag = tag;
        if (bg) begin
            if (b == 8'hB8 && !uc) begin
                m_pos  = 0;
                m_lock = 1;
            end else begin
                m_pos = (m_pos == 7) ? 0 : m_pos + 1;
            end
            if (m_pos == 0) m_st = SEED;
            else            msk = gen8(m_st);
            m_bad   = uc;
            m_err   = uc || !m_lock;
            m_state = 1;
            exp     = b;
            dtag    = "R3";
        end else if (m_state == 0) begin
            exp  = b;
            dtag = "R10";
        end else begin
            msk = gen8(m_st);
            exp = b ^ msk;
            if (m_state == 1) begin
                if (erf_en && m_bad) exp = exp | 8'h80;
                dtag = "R8";
            end
            m_state = 2;
        end
        in_byte   = b;
        in_begin  = bg;
        in_uncorr = uc;
        in_stb    = 1'b1;
        @(negedge clk);
        check(out_stb && (out_begin == bg), "R2", {30'd0, out_stb, out_begin}, {30'd0, 1'b1, bg});
        check(out_byte == exp, dtag, {24'd0, out_byte}, {24'd0, exp});
        check(out_err == m_err, "R9", {31'd0, out_err}, {31'd0, m_err});
    endtask

    task automatic gap();
        in_stb    = 1'b0;
        in_byte   = 8'($urandom);
        in_begin  = 1'($urandom);
        in_uncorr = 1'($urandom);
        @(negedge clk);
        check(!out_stb && !out_begin, "R11", {30'd0, out_stb, out_begin}, 32'd0);
    endtask

    task automatic send_pkt(input logic [7:0] sync, input bit uc, input int gap_pct, input string tag);
        for (int i = 0; i < PKT_LEN; i++) begin
            if (gap_pct > 0 && $urandom_range(99) < gap_pct) gap();
            send((i == 0) ? sync : 8'($urandom), i == 0, uc, tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5C_0A7E));
        rst_n = 1'b0; erf_en = 1'b1; in_byte = 8'h00; in_stb = 1'b0; in_begin = 1'b0; in_uncorr = 1'b0;
        m_st = SEED; m_pos = 0; m_lock = 0; m_state = 0; m_bad = 0; m_err = 1;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(out_stb == 1'b0, "R1", {31'd0, out_stb}, 32'd0);
        check(out_begin == 1'b0, "R1", {31'd0, out_begin}, 32'd0);
        check(out_byte == 8'h00, "R1", {24'd0, out_byte}, 32'd0);
        check(out_err == 1'b1, "R1", {31'd0, out_err}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_stb && out_err, "R1", {30'd0, out_stb, out_err}, 32'd1);

        // R10: bytes before the first sync pass through
        send(8'h5A, 0, 0, "R10");
        send(8'hC3, 0, 1, "R10");
        gap();
        send(8'hFF, 0, 0, "R10");

        // R7: pre-lock packets, counter runs from 0
        send_pkt(8'h47, 0, 0, "R7");
        send_pkt(8'h47, 0, 0, "R7");

        // R5 / R6: locked frame, first packet B8h then seven 47h
        send_pkt(8'hB8, 0, 0, "R5");
        for (int p = 1; p < 8; p++) send_pkt(8'h47, 0, 0, "R6");

        // R7: frame start with a damaged sync value still reloads
        send_pkt(8'h47, 0, 0, "R7");
        for (int p = 1; p < 8; p++) send_pkt(8'h47, 0, 0, "R7");

        // R4 / R8: uncorrectable B8h mid-frame does not resync; TEI forcing on and off
        send_pkt(8'hB8, 0, 0, "R4");
        send_pkt(8'h47, 0, 0, "R4");
        send_pkt(8'hB8, 1, 0, "R4");
        send_pkt(8'h47, 0, 0, "R4");
        erf_en = 1'b0;
        send_pkt(8'h47, 1, 0, "R8");
        erf_en = 1'b1;
        send_pkt(8'h47, 1, 0, "R8");
        // R4: clean B8h at position 6 resyncs
        send_pkt(8'hB8, 0, 0, "R4");
        send_pkt(8'h47, 0, 0, "R4");

        // R11: random traffic with gaps, random error packets and enable
        for (int f = 0; f < 3; f++) begin
            for (int p = 0; p < 8; p++) begin
                erf_en = 1'($urandom);
                send_pkt((p == 0) ? 8'hB8 : 8'h47, ($urandom_range(7) == 0), 20, "R11");
            end
        end

        in_stb = 1'b0;
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule